// File: doc/BRIEF.md
# Product-Term Logic Cell

This block is one programmable cell of a sum-of-products logic fabric. Each input signal is offered to an AND array as two literals, its true value and its complement. Every crosspoint of that array is a configuration bit. Each product term is the AND of the literals whose crosspoints are enabled. A term with no enabled crosspoint reads as 0, so a spare term never forces the sum high. An allocator mask then chooses which terms are ORed into the single combinational sum of the cell.

The sum feeds a storage stage that can be set up as a D flip-flop or as a T flip-flop, or bypassed so that the sum reaches the output directly. The register's clock is either the global clock or a selected product term. Its asynchronous clear is either the global clear alone, or the global clear ORed with a selected product term. A final polarity bit can invert the output. The result appears both on the pin output and on a feedback output that neighbouring cells can take as an input.

All configuration is static and arrives on plain input buses. A typical use fills two terms with `A·C·!D` and `B·C·!D`, allocates both, and registers the sum on the global clock.

Top module: `pterm_macrocell`

## Requirements
- R1: Input `sigIn[i]` supplies literal `2*i` (true value) and literal `2*i+1` (inverted value). Product term `t` reads its crosspoint bits from `cfgCross[t*2*NUM_IN + l]`, where `l` is the literal index.
- R2: A product term is 1 exactly when every literal whose crosspoint bit is 1 evaluates to 1.
- R3: A product term with no crosspoint bit set evaluates to 0.
- R4: The cell sum is the OR of the product terms `t` for which `cfgAlloc[t]` is 1. With an all-zero mask the sum is 0.
- R5: With `cfgBypass`=1, `cellOut` follows the sum combinationally, and the register state has no effect on it.
- R6: With `cfgToggle`=0, `cfgClkTerm`=0 and `cfgBypass`=0, the register loads the sum on each rising `gclk` edge. `cellOut` does not change before that edge.
- R7: With `cfgToggle`=1, the register inverts on a clock edge when the sum is 1, and holds its value when the sum is 0.
- R8: With `cfgClkTerm`=1, the register is clocked only by the rising edge of product term `cfgClkIdx`, and `gclk` edges leave it unchanged.
- R9: `grst`=1 clears the register to 0 at once, without waiting for a clock. With `cfgClrTerm`=1, product term `cfgClrIdx` at 1 does the same.
- R10: With `cfgInvert`=1, `cellOut` is the complement of the value it would have with `cfgInvert`=0.
- R11: `fbOut` always equals `cellOut`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| gclk | input | 1 | Global clock |
| grst | input | 1 | Global asynchronous clear, active high |
| sigIn | input | NUM_IN | Input signals to the AND array |
| cfgCross | input | NUM_PT*2*NUM_IN | Crosspoint enables, one group of 2*NUM_IN bits per term |
| cfgAlloc | input | NUM_PT | Mask of the terms ORed into the sum |
| cfgToggle | input | 1 | 0 selects D flip-flop, 1 selects T flip-flop |
| cfgClkTerm | input | 1 | 0 clocks the register from gclk, 1 from a product term |
| cfgClkIdx | input | IDX_W | Index of the product term used as clock |
| cfgClrTerm | input | 1 | 1 adds a product term as an extra clear source |
| cfgClrIdx | input | IDX_W | Index of the product term used as clear |
| cfgBypass | input | 1 | 1 routes the sum around the register |
| cfgInvert | input | 1 | 1 inverts the cell output |
| cellOut | output | 1 | Pin output of the cell |
| fbOut | output | 1 | Feedback copy of the output for other cells |

## Verification
Bypassed and inverted results are combinational, so each one is sampled 1 ns after its input changes, with no clock edge in between. Registered results are due at the first rising `gclk` edge after the inputs change. Each is checked once just before that edge, to confirm the old value still holds, and again at the following falling edge against the bench model, which updates only then. Clears and product-term clocks act without `gclk`, so the bench checks them 1 ns after the input change that causes them. It then runs further global clock cycles to confirm that nothing else changed.

// File: rtl/mc_pkg.sv
`timescale 1ns/1ps
package mc_pkg;

  // Strobes handed from the control module to the storage datapath.
  typedef struct packed {
    logic regClk;     // selected register clock
    logic regClr;     // combined asynchronous clear
    logic globalClk;  // clock currently taken from the global line
    logic toggle;     // T behaviour when set, D otherwise
    logic bypass;     // route sum around the register
    logic invert;     // output polarity
  } mc_strobe_t;

endpackage

// File: rtl/mc_sop_array.sv
`timescale 1ns/1ps
module mc_sop_array #(
  parameter int NUM_IN = 8,
  parameter int NUM_PT = 5
) (
  input  logic [NUM_IN-1:0]          sigIn,
  input  logic [NUM_PT*2*NUM_IN-1:0] cfgCross,
  input  logic [NUM_PT-1:0]          cfgAlloc,
  output logic [NUM_PT-1:0]          ptTerm,
  output logic                       sumOut
);

  localparam int LIT_W = 2 * NUM_IN;

  logic [LIT_W-1:0] literal;

  // Even literal is the true input, odd literal its complement.
  for (genvar i = 0; i < NUM_IN; i++) begin : g_lit
    assign literal[2*i]   = sigIn[i];
    assign literal[2*i+1] = ~sigIn[i];
  end

  for (genvar t = 0; t < NUM_PT; t++) begin : g_term
    logic [LIT_W-1:0] mask;
    logic             anyUsed;
    logic             allMet;
    assign mask    = cfgCross[t*LIT_W +: LIT_W];
    assign anyUsed = |mask;
    // A literal outside the mask is treated as satisfied.
    assign allMet  = &(literal | ~mask);
    // An empty term is forced low so it cannot pull the sum high.
    assign ptTerm[t] = anyUsed & allMet;
  end

  assign sumOut = |(ptTerm & cfgAlloc);

endmodule

// File: rtl/mc_ctrl.sv
`timescale 1ns/1ps
module mc_ctrl
  import mc_pkg::*;
#(
  parameter int NUM_PT = 5,
  parameter int IDX_W  = 3
) (
  input  logic              gclk,
  input  logic              grst,
  input  logic [NUM_PT-1:0] ptTerm,
  input  logic              cfgToggle,
  input  logic              cfgClkTerm,
  input  logic [IDX_W-1:0]  cfgClkIdx,
  input  logic              cfgClrTerm,
  input  logic [IDX_W-1:0]  cfgClrIdx,
  input  logic              cfgBypass,
  input  logic              cfgInvert,
  output mc_strobe_t        strb
);

  logic clkPick;
  logic clrPick;

  // Index selection written as a compare per term, so an index
  // beyond the last term simply selects nothing.
  always_comb begin
    clkPick = 1'b0;
    clrPick = 1'b0;
    for (int t = 0; t < NUM_PT; t++) begin
      if (cfgClkIdx == IDX_W'(t)) clkPick = ptTerm[t];
      if (cfgClrIdx == IDX_W'(t)) clrPick = ptTerm[t];
    end
  end

  always_comb begin
    strb.regClk    = cfgClkTerm ? clkPick : gclk;
    strb.globalClk = ~cfgClkTerm;
    strb.regClr    = grst | (cfgClrTerm & clrPick);
    strb.toggle    = cfgToggle;
    strb.bypass    = cfgBypass;
    strb.invert    = cfgInvert;
  end

endmodule

// File: rtl/mc_store.sv
`timescale 1ns/1ps
module mc_store
  import mc_pkg::*;
(
  input  logic       gclk,
  input  logic       grst,
  input  mc_strobe_t strb,
  input  logic       sumIn,
  output logic       cellOut,
  output logic       fbOut
);

  logic regClk;
  logic regClr;
  logic regQ;
  logic preOut;

  assign regClk = strb.regClk;
  assign regClr = strb.regClr;

  always_ff @(posedge regClk or posedge regClr) begin
    if (regClr)          regQ <= 1'b0;
    else if (strb.toggle) regQ <= regQ ^ sumIn;
    else                 regQ <= sumIn;
  end

  assign preOut  = strb.bypass ? sumIn : regQ;
  assign cellOut = preOut ^ strb.invert;
  assign fbOut   = cellOut;

  // R6: on the global clock in D mode the register holds the prior sum
  a_r6_d_capture: assert property (@(posedge gclk) disable iff (grst)
    (strb.globalClk && !strb.toggle && !strb.regClr)
      |=> (strb.regClr || !strb.globalClk || regQ == $past(sumIn)));

  // R7: T mode keeps its state when the sum is low
  a_r7_t_hold: assert property (@(posedge gclk) disable iff (grst)
    (strb.globalClk && strb.toggle && !strb.regClr && !sumIn)
      |=> (strb.regClr || !strb.globalClk || regQ == $past(regQ)));

  // R7: T mode flips its state when the sum is high
  a_r7_t_flip: assert property (@(posedge gclk) disable iff (grst)
    (strb.globalClk && strb.toggle && !strb.regClr && sumIn)
      |=> (strb.regClr || !strb.globalClk || regQ != $past(regQ)));

  // R9: while a clear source is active the register reads zero
  a_r9_clear_zero: assert property (@(posedge gclk) disable iff (grst)
    strb.regClr |-> !regQ);

endmodule

// File: rtl/pterm_macrocell.sv
`timescale 1ns/1ps
module pterm_macrocell
  import mc_pkg::*;
#(
  parameter int NUM_IN = 8,
  parameter int NUM_PT = 5,
  parameter int IDX_W  = (NUM_PT > 1) ? $clog2(NUM_PT) : 1
) (
  input  logic                       gclk,
  input  logic                       grst,
  input  logic [NUM_IN-1:0]          sigIn,
  input  logic [NUM_PT*2*NUM_IN-1:0] cfgCross,
  input  logic [NUM_PT-1:0]          cfgAlloc,
  input  logic                       cfgToggle,
  input  logic                       cfgClkTerm,
  input  logic [IDX_W-1:0]           cfgClkIdx,
  input  logic                       cfgClrTerm,
  input  logic [IDX_W-1:0]           cfgClrIdx,
  input  logic                       cfgBypass,
  input  logic                       cfgInvert,
  output logic                       cellOut,
  output logic                       fbOut
);

  logic [NUM_PT-1:0] ptTerm;
  logic              sumBit;
  mc_strobe_t        strb;

  mc_sop_array #(.NUM_IN(NUM_IN), .NUM_PT(NUM_PT)) u_array (
    .sigIn   (sigIn),
    .cfgCross(cfgCross),
    .cfgAlloc(cfgAlloc),
    .ptTerm  (ptTerm),
    .sumOut  (sumBit)
  );

  mc_ctrl #(.NUM_PT(NUM_PT), .IDX_W(IDX_W)) u_ctrl (
    .gclk      (gclk),
    .grst      (grst),
    .ptTerm    (ptTerm),
    .cfgToggle (cfgToggle),
    .cfgClkTerm(cfgClkTerm),
    .cfgClkIdx (cfgClkIdx),
    .cfgClrTerm(cfgClrTerm),
    .cfgClrIdx (cfgClrIdx),
    .cfgBypass (cfgBypass),
    .cfgInvert (cfgInvert),
    .strb      (strb)
  );

  mc_store u_store (
    .gclk   (gclk),
    .grst   (grst),
    .strb   (strb),
    .sumIn  (sumBit),
    .cellOut(cellOut),
    .fbOut  (fbOut)
  );

endmodule

// File: tb/tb_pterm_macrocell.sv
`timescale 1ns/1ps
module tb_pterm_macrocell;

  logic        gclk = 1'b0;
  logic        grst;
  logic [7:0]  sigIn;
  logic [79:0] cfgCross;
  logic [4:0]  cfgAlloc;
  logic        cfgToggle, cfgClkTerm, cfgClrTerm, cfgBypass, cfgInvert;
  logic [2:0]  cfgClkIdx, cfgClrIdx;
  logic        cellOut, fbOut;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  bit refQ = 0;
  logic [15:0] lf = 16'hACE1;

  always #5 gclk = ~gclk;

  pterm_macrocell dut (
    .gclk(gclk), .grst(grst), .sigIn(sigIn), .cfgCross(cfgCross),
    .cfgAlloc(cfgAlloc), .cfgToggle(cfgToggle), .cfgClkTerm(cfgClkTerm),
    .cfgClkIdx(cfgClkIdx), .cfgClrTerm(cfgClrTerm), .cfgClrIdx(cfgClrIdx),
    .cfgBypass(cfgBypass), .cfgInvert(cfgInvert),
    .cellOut(cellOut), .fbOut(fbOut)
  );

  // Behavioural reference of one product term.
  function automatic bit refTerm(input int t, input logic [7:0] v);
    logic [15:0] m;
    m = cfgCross[t*16 +: 16];
    if (m == 16'h0) return 1'b0;
    for (int i = 0; i < 8; i++) begin
      if (m[2*i] && !v[i]) return 1'b0;
      if (m[2*i+1] && v[i]) return 1'b0;
    end
    return 1'b1;
  endfunction

  function automatic bit refSum(input logic [7:0] v);
    for (int t = 0; t < 5; t++)
      if (cfgAlloc[t] && refTerm(t, v)) return 1'b1;
    return 1'b0;
  endfunction

  task automatic check(input logic act, input logic exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic nextLfsr();
    lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
  endtask

  // One global clock cycle with the register model; called away from edges.
  task automatic tick(input logic [7:0] v, input string req);
    bit s;
    sigIn = v;
    #1;
    check(cellOut, refQ ^ cfgInvert, req);   // no change before the edge
    s = refSum(v);
    @(posedge gclk);
    @(negedge gclk);
    refQ = cfgToggle ? (refQ ^ s) : s;
    check(cellOut, refQ ^ cfgInvert, req);
    check(fbOut, cellOut, "R11");
  endtask

  initial begin
    // f = A.C.!D + B.C.!D with A..D on inputs 0..3
    cfgCross = '0;
    cfgCross[0*16 + 0] = 1'b1;  // A true
    cfgCross[0*16 + 4] = 1'b1;  // C true
    cfgCross[0*16 + 7] = 1'b1;  // D inverted
    cfgCross[1*16 + 2] = 1'b1;  // B true
    cfgCross[1*16 + 4] = 1'b1;
    cfgCross[1*16 + 7] = 1'b1;
    cfgCross[3*16 + 12] = 1'b1; // term 3 = input 6 true (clear source)
    cfgCross[4*16 + 14] = 1'b1; // term 4 = input 7 true (clock source)
    cfgAlloc = 5'b00011;
    cfgToggle = 0; cfgClkTerm = 0; cfgClrTerm = 0;
    cfgBypass = 0; cfgInvert = 0;
    cfgClkIdx = 3'd4; cfgClrIdx = 3'd3;
    sigIn = 8'h05;
    grst = 1'b1;
    repeat (3) @(negedge gclk);
    check(cellOut, 1'b0, "R9 reset state");
    check(fbOut, 1'b0, "R11 reset state");
    grst = 1'b0;

    // Bypass: exhaustive combinational sweep
    cfgBypass = 1;
    for (int v = 0; v < 256; v++) begin
      @(negedge gclk);
      sigIn = v[7:0];
      #1;
      check(cellOut, refSum(v[7:0]), "R5 R2 bypass sum");
      check(fbOut, cellOut, "R11");
    end
    // Polarity
    cfgInvert = 1;
    for (int v = 0; v < 16; v++) begin
      @(negedge gclk);
      sigIn = v[7:0];
      #1;
      check(cellOut, ~refSum(v[7:0]), "R10 inverted output");
    end
    cfgInvert = 0;

    // Allocating an empty term changes nothing
    cfgAlloc = 5'b00111;
    for (int v = 0; v < 16; v++) begin
      @(negedge gclk); sigIn = v[7:0]; #1;
      check(cellOut, refSum(v[7:0]), "R3 empty term in sum");
    end
    cfgAlloc = 5'b00100;
    @(negedge gclk); sigIn = 8'h00; #1;
    check(cellOut, 1'b0, "R3 empty term alone");
    sigIn = 8'hFF; #1;
    check(cellOut, 1'b0, "R3 empty term alone");
    cfgAlloc = 5'b00000; sigIn = 8'h05; #1;
    check(cellOut, 1'b0, "R4 empty allocator");
    cfgAlloc = 5'b00001; sigIn = 8'h06; #1;
    check(cellOut, 1'b0, "R4 only term 0 allocated");
    sigIn = 8'h05; #1;
    check(cellOut, 1'b1, "R4 only term 0 allocated");
    // Single inverted literal: term 2 = !input5 (literal 11)
    cfgCross[2*16 + 11] = 1'b1;
    cfgAlloc = 5'b00100;
    sigIn = 8'h00; #1;
    check(cellOut, 1'b1, "R1 inverted literal");
    sigIn = 8'h20; #1;
    check(cellOut, 1'b0, "R1 inverted literal");
    cfgCross[2*16 + 11] = 1'b0;
    cfgAlloc = 5'b00011;

    // Registered D mode on the global clock
    cfgBypass = 0;
    @(posedge gclk);
    @(negedge gclk);
    refQ = refSum(sigIn);
    for (int n = 0; n < 300; n++) begin
      nextLfsr();
      tick({2'b00, lf[5:0]}, "R6 D capture");
    end
    // T mode
    cfgToggle = 1;
    for (int n = 0; n < 200; n++) begin
      nextLfsr();
      tick({2'b00, lf[5:0]}, "R7 T toggle/hold");
    end
    cfgInvert = 1;
    for (int n = 0; n < 20; n++) begin
      nextLfsr();
      tick({2'b00, lf[5:0]}, "R10 R7 inverted T");
    end
    cfgInvert = 0;
    cfgToggle = 0;

    // Clear from a product term
    cfgClrTerm = 1;
    tick(8'h05, "R6 setup for clear");
    sigIn = 8'h45; #1;
    check(cellOut, 1'b0, "R9 term clear immediate");
    @(posedge gclk); @(negedge gclk);
    check(cellOut, 1'b0, "R9 term clear held over edge");
    refQ = 0;
    tick(8'h05, "R9 released term clear");
    cfgClrTerm = 0;
    // Term 3 active but not selected as clear source: no effect
    tick(8'h45, "R9 unselected clear ignored");
    tick(8'h05, "R6");
    // Global clear mid-run
    grst = 1'b1; #1;
    check(cellOut, 1'b0, "R9 global clear immediate");
    @(posedge gclk); @(negedge gclk);
    grst = 1'b0;
    refQ = 0;
    check(cellOut, 1'b0, "R9 global clear held");
    tick(8'h05, "R6 after global clear");

    // Clock from product term 4 (input 7)
    cfgClkTerm = 1;
    sigIn = 8'h00;
    repeat (3) @(negedge gclk);
    check(cellOut, 1'b1, "R8 global clock ignored");
    sigIn = 8'h80; #1;
    check(cellOut, 1'b0, "R8 term edge captures sum 0");
    sigIn = 8'h85;
    repeat (2) @(negedge gclk);
    check(cellOut, 1'b0, "R8 no term edge no change");
    sigIn = 8'h05; #1;
    check(cellOut, 1'b0, "R8 falling term edge ignored");
    sigIn = 8'h85; #1;
    check(cellOut, 1'b1, "R8 term edge captures sum 1");
    check(fbOut, 1'b1, "R11 feedback with term clock");
    cfgClkTerm = 0;

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule